// File: doc/BRIEF.md
# Precision Time Clock with Staged Commands

This block keeps a free-running 96-bit time value: a high nanosecond word, a low nanosecond word and a fraction word that holds sub-nanosecond resolution. While the timer is enabled, a programmable 40-bit increment is added on every clock. The increment spans the fraction word and the bottom 8 bits of the low nanosecond word, so any carry moves up through the low and high nanosecond words.

Software never writes the running time directly. It fills staging registers over a plain write strobe and picks an operation in the command register. It then writes the execute value to the sync register. One cycle later the chosen operation takes effect as a single step, and the command register clears. The operations are:

- load a new time
- load a new increment
- add a signed nanosecond offset
- copy the full time into snapshot registers, which software then reads word by word without tearing

Top module: `ptp_hw_clock`

## Requirements
- R1: After reset the time, the increment, the snapshot words, the enable bit and the armed command all read zero.
- R2: With the enable bit (bit 0 of the control word at address 0) clear, the time holds. With it set, each clock adds the 40-bit increment to the 64-bit value {low ns, fraction}, and the carry propagates into the high ns word.
- R3: Writing the command word (address 1, bits 2:0) only arms an operation. Nothing changes until the value 1 is written to the sync word (address 2). A sync write with any other value is ignored, and the armed command is kept.
- R4: The armed operation is applied on the clock edge after the sync write, and the command word then reads 0. A later sync write with no new command changes nothing.
- R5: Command 1 loads the three time words from the staging words: high ns at address 5, low ns at address 4, fraction at address 3. In that cycle the load replaces the increment step.
- R6: Command 2 sets the increment to {bits 7:0 of the word at address 7, the word at address 6}. The increment reads back at addresses 11 (low 32 bits) and 12 (upper 8 bits).
- R7: Command 3 adds the word at address 7, taken as a signed two's-complement nanosecond count, to the 64-bit nanosecond time, with carry or borrow into the high word. The word at address 6 is ignored, and the fraction word does not change.
- R8: Command 4 copies the whole time in one cycle into the snapshot words: fraction at address 8, low ns at 9, high ns at 10.
- R9: Command 5 (adjust at a set time) and any other code besides 1 to 4 executes as a no-op. It leaves the time, the increment and the snapshot unchanged.
- R10: The control word and all staging words read back the values last written. The sync word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one increment step per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| time_o | output | 96 | Live time {high ns, low ns, fraction} |

## Verification
Several properties are checked on every cycle:

- the time holds when the timer is disabled and no command is applied, and steps by exactly the current increment when it is enabled;
- only one operation is applied at a time;
- a time load and a snapshot reproduce the previous cycle's staging value and time;
- an execute write always fires one cycle later, and any other sync value never fires;
- the command word is cleared once its operation has run.

Other behaviour can only be shown by the bench's scenarios, because it depends on numeric results over many cycles:

- carries from the fraction word through to the high word across a run of ticks;
- borrows from a negative adjustment;
- a load taking priority over a running increment;
- that the low staging word has no effect on an adjustment;
- that the no-op codes leave every readable word unchanged.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

  localparam int AW    = 4;
  localparam int CMD_W = 3;

  localparam logic [AW-1:0] A_CTRL      = 4'd0;
  localparam logic [AW-1:0] A_CMD       = 4'd1;
  localparam logic [AW-1:0] A_SYNC      = 4'd2;
  localparam logic [AW-1:0] A_SH_FRAC   = 4'd3;
  localparam logic [AW-1:0] A_SH_TLO    = 4'd4;
  localparam logic [AW-1:0] A_SH_THI    = 4'd5;
  localparam logic [AW-1:0] A_SH_ADJ_LO = 4'd6;
  localparam logic [AW-1:0] A_SH_ADJ_HI = 4'd7;
  localparam logic [AW-1:0] A_SNAP_FRAC = 4'd8;
  localparam logic [AW-1:0] A_SNAP_TLO  = 4'd9;
  localparam logic [AW-1:0] A_SNAP_THI  = 4'd10;
  localparam logic [AW-1:0] A_INC_LO    = 4'd11;
  localparam logic [AW-1:0] A_INC_HI    = 4'd12;

  localparam int unsigned SYNC_EXEC = 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE        = 3'd0,
    CMD_INIT_TIME   = 3'd1,
    CMD_INIT_INC    = 3'd2,
    CMD_ADJ_TIME    = 3'd3,
    CMD_READ_TIME   = 3'd4,
    CMD_ADJ_AT_TIME = 3'd5
  } tmr_cmd_e;

  typedef struct packed {
    logic init_time;
    logic init_inc;
    logic adj_time;
    logic read_time;
  } apply_t;

endpackage

// File: rtl/ptp_shadow_regs.sv
module ptp_shadow_regs
  import ptp_clk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             enable_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             go_o,
  output logic [DW-1:0]    sh_frac_o,
  output logic [DW-1:0]    sh_tlo_o,
  output logic [DW-1:0]    sh_thi_o,
  output logic [DW-1:0]    sh_adj_lo_o,
  output logic [DW-1:0]    sh_adj_hi_o
);

  localparam int NSH = 5;
  localparam logic [DW-1:0] EXEC_VAL = DW'(SYNC_EXEC);

  logic             en_q;
  logic [CMD_W-1:0] cmd_q;
  logic             go_q;
  logic [DW-1:0]    sh_q [NSH];

  logic wr_cmd, wr_sync_exec, wr_sync_other;
  assign wr_cmd        = we_i && (addr_i == A_CMD);
  assign wr_sync_exec  = we_i && (addr_i == A_SYNC) && (wdata_i == EXEC_VAL);
  assign wr_sync_other = we_i && (addr_i == A_SYNC) && (wdata_i != EXEC_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == A_CTRL) en_q <= wdata_i[0];
      if (wr_cmd)    cmd_q <= wdata_i[CMD_W-1:0];
      else if (go_q) cmd_q <= '0;  // armed command consumed
      go_q <= wr_sync_exec;
    end
  end

  // staging words occupy consecutive addresses from A_SH_FRAC
  for (genvar g = 0; g < NSH; g++) begin : g_sh
    localparam logic [AW-1:0] MY_ADDR = A_SH_FRAC + AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          sh_q[g] <= '0;
      else if (we_i && addr_i == MY_ADDR)   sh_q[g] <= wdata_i;
    end
  end

  assign enable_o    = en_q;
  assign cmd_o       = cmd_q;
  assign go_o        = go_q;
  assign sh_frac_o   = sh_q[0];
  assign sh_tlo_o    = sh_q[1];
  assign sh_thi_o    = sh_q[2];
  assign sh_adj_lo_o = sh_q[3];
  assign sh_adj_hi_o = sh_q[4];

  assert_sync_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sync_exec |=> go_q);
  assert_sync_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sync_other |=> !go_q);
  assert_cmd_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !wr_cmd) |=> (cmd_q == '0));

endmodule

// File: rtl/ptp_cmd_decode.sv
module ptp_cmd_decode
  import ptp_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CMD_W-1:0] cmd_i,
  output apply_t           apply_o
);

  always_comb begin
    apply_o = '0;
    if (go_i) begin
      unique case (cmd_i)
        CMD_INIT_TIME: apply_o.init_time = 1'b1;
        CMD_INIT_INC:  apply_o.init_inc  = 1'b1;
        CMD_ADJ_TIME:  apply_o.adj_time  = 1'b1;
        CMD_READ_TIME: apply_o.read_time = 1'b1;
        default:       apply_o = '0;  // none, adjust-at-time, reserved
      endcase
    end
  end

  assert_onehot_apply_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(apply_o));
  assert_idle_no_apply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |-> (apply_o == '0));

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_clk_pkg::*;
#(
  parameter int DW       = 32,
  parameter int INC_HI_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  apply_t            apply_i,
  input  logic [DW-1:0]     sh_frac_i,
  input  logic [DW-1:0]     sh_tlo_i,
  input  logic [DW-1:0]     sh_thi_i,
  input  logic [DW-1:0]     sh_adj_lo_i,
  input  logic [DW-1:0]     sh_adj_hi_i,
  output logic [3*DW-1:0]   time_o,
  output logic [3*DW-1:0]   snap_o,
  output logic [DW+INC_HI_W-1:0] inc_o
);

  localparam int TW    = 3 * DW;
  localparam int INC_W = DW + INC_HI_W;

  logic [TW-1:0]    time_q, time_d, snap_q;
  logic [INC_W-1:0] inc_q;
  logic [TW-1:0]    inc_ext, adj_ext, step;

  assign inc_ext = {{(TW-INC_W){1'b0}}, inc_q};
  // signed ns offset aligned to the low ns word, sign-extended into high word
  assign adj_ext = {{DW{sh_adj_hi_i[DW-1]}}, sh_adj_hi_i, {DW{1'b0}}};
  assign step    = enable_i ? inc_ext : '0;

  always_comb begin
    if (apply_i.init_time) time_d = {sh_thi_i, sh_tlo_i, sh_frac_i};
    else if (apply_i.adj_time) time_d = time_q + step + adj_ext;
    else time_d = time_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      snap_q <= '0;
      inc_q  <= '0;
    end else begin
      time_q <= time_d;
      if (apply_i.read_time) snap_q <= time_q;
      if (apply_i.init_inc)  inc_q  <= {sh_adj_hi_i[INC_HI_W-1:0], sh_adj_lo_i};
    end
  end

  assign time_o = time_q;
  assign snap_o = snap_q;
  assign inc_o  = inc_q;

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && apply_i == '0) |=> $stable(time_q));
  assert_tick_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && apply_i == '0) |=> (time_q == $past(time_q + inc_ext)));
  assert_init_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i.init_time |=> (time_q == $past({sh_thi_i, sh_tlo_i, sh_frac_i})));
  assert_snapshot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i.read_time |=> (snap_q == $past(time_q)));
  assert_snap_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i.read_time |=> $stable(snap_q));
  assert_inc_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i.init_inc |=> $stable(inc_q));

endmodule

// File: rtl/ptp_hw_clock.sv
module ptp_hw_clock
  import ptp_clk_pkg::*;
#(
  parameter int DW       = 32,
  parameter int INC_HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [3*DW-1:0] time_o
);

  localparam int TW    = 3 * DW;
  localparam int INC_W = DW + INC_HI_W;

  logic             enable;
  logic [CMD_W-1:0] cmd;
  logic             go;
  logic [DW-1:0]    sh_frac, sh_tlo, sh_thi, sh_adj_lo, sh_adj_hi;
  apply_t           apply;
  logic [TW-1:0]    time_w, snap_w;
  logic [INC_W-1:0] inc_w;

  ptp_shadow_regs #(.DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .enable_o    (enable),
    .cmd_o       (cmd),
    .go_o        (go),
    .sh_frac_o   (sh_frac),
    .sh_tlo_o    (sh_tlo),
    .sh_thi_o    (sh_thi),
    .sh_adj_lo_o (sh_adj_lo),
    .sh_adj_hi_o (sh_adj_hi)
  );

  ptp_cmd_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .cmd_i   (cmd),
    .apply_o (apply)
  );

  ptp_time_core #(.DW(DW), .INC_HI_W(INC_HI_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .apply_i     (apply),
    .sh_frac_i   (sh_frac),
    .sh_tlo_i    (sh_tlo),
    .sh_thi_i    (sh_thi),
    .sh_adj_lo_i (sh_adj_lo),
    .sh_adj_hi_i (sh_adj_hi),
    .time_o      (time_w),
    .snap_o      (snap_w),
    .inc_o       (inc_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:      reg_rdata_o = {{(DW-1){1'b0}}, enable};
      A_CMD:       reg_rdata_o = {{(DW-CMD_W){1'b0}}, cmd};
      A_SH_FRAC:   reg_rdata_o = sh_frac;
      A_SH_TLO:    reg_rdata_o = sh_tlo;
      A_SH_THI:    reg_rdata_o = sh_thi;
      A_SH_ADJ_LO: reg_rdata_o = sh_adj_lo;
      A_SH_ADJ_HI: reg_rdata_o = sh_adj_hi;
      A_SNAP_FRAC: reg_rdata_o = snap_w[DW-1:0];
      A_SNAP_TLO:  reg_rdata_o = snap_w[2*DW-1:DW];
      A_SNAP_THI:  reg_rdata_o = snap_w[3*DW-1:2*DW];
      A_INC_LO:    reg_rdata_o = inc_w[DW-1:0];
      A_INC_HI:    reg_rdata_o = {{(DW-INC_HI_W){1'b0}}, inc_w[INC_W-1:DW]};
      default:     reg_rdata_o = '0;  // sync word and unmapped
    endcase
  end

  assign time_o = time_w;

endmodule

// File: tb/ptp_hw_clock_tb_top.sv
`timescale 1ns/1ps
module ptp_hw_clock_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [95:0] tm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_hw_clock dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .time_o      (tm)
  );

  typedef struct {
    bit          is_time;
    logic [95:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [95:0] act;
      it  = sb_q.pop_front();
      act = it.is_time ? tm : {64'h0, rdata};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    #1;
    it.is_time = 1'b0; it.exp = {64'h0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic exp_time(input logic [95:0] e, input string tag);
    item_t it;
    #1;
    it.is_time = 1'b1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic run_cmd(input logic [31:0] c);
    wr(4'd1, c);
    wr(4'd2, 32'h1);
    idle(2);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    exp_time(96'h0, "R1 time");
    exp_reg(4'd11, 32'h0, "R1 inc_lo");
    exp_reg(4'd10, 32'h0, "R1 snap_hi");
    exp_reg(4'd0,  32'h0, "R1 enable");
    exp_reg(4'd1,  32'h0, "R1 cmd");

    // R3 arming alone and wrong sync value change nothing
    wr(4'd5, 32'h5);
    wr(4'd4, 32'hFFFF_FFF0);
    wr(4'd3, 32'h0000_1234);
    wr(4'd1, 32'h1);
    idle(3);
    exp_time(96'h0, "R3 armed only");
    wr(4'd2, 32'h2);
    idle(3);
    exp_time(96'h0, "R3 bad sync");
    exp_reg(4'd1, 32'h1, "R3 cmd kept");
    exp_reg(4'd5, 32'h5, "R10 shadow hi");
    exp_reg(4'd2, 32'h0, "R10 sync reads 0");

    // R5 init time
    wr(4'd2, 32'h1);
    idle(2);
    exp_time({32'h5, 32'hFFFF_FFF0, 32'h1234}, "R5 init time");
    exp_reg(4'd1, 32'h0, "R4 cmd cleared");

    // R6 init increment (3.5 ns), upper bits of adj_hi beyond 8 dropped
    wr(4'd6, 32'h8000_0000);
    wr(4'd7, 32'h0000_AB03);
    run_cmd(32'h2);
    exp_reg(4'd11, 32'h8000_0000, "R6 inc lo");
    exp_reg(4'd12, 32'h0000_0003, "R6 inc hi");
    exp_time({32'h5, 32'hFFFF_FFF0, 32'h1234}, "R2 disabled hold");

    // R2 eight ticks: +28 ns, carry into high word
    wr(4'd0, 32'h1);
    idle(7);
    wr(4'd0, 32'h0);
    idle(1);
    exp_time({32'h6, 32'h0000_000C, 32'h1234}, "R2 eight ticks");
    idle(5);
    exp_time({32'h6, 32'h0000_000C, 32'h1234}, "R2 hold after disable");

    // R8 snapshot
    run_cmd(32'h4);
    exp_reg(4'd8,  32'h1234, "R8 snap frac");
    exp_reg(4'd9,  32'hC,    "R8 snap lo");
    exp_reg(4'd10, 32'h6,    "R8 snap hi");

    // R7 positive adjust, low adjust word ignored
    wr(4'd6, 32'h1234_5678);
    wr(4'd7, 32'd100);
    run_cmd(32'h3);
    exp_time({32'h6, 32'h0000_0070, 32'h1234}, "R7 adjust +100");

    // R4 repeated sync with no armed command
    wr(4'd2, 32'h1);
    idle(2);
    exp_time({32'h6, 32'h0000_0070, 32'h1234}, "R4 second sync");

    // R7 negative adjust with borrow
    wr(4'd7, 32'hFFFF_FF80);
    run_cmd(32'h3);
    exp_time({32'h5, 32'hFFFF_FFF0, 32'h1234}, "R7 adjust -128");
    wr(4'd7, 32'h20);
    run_cmd(32'h3);
    exp_time({32'h6, 32'h0000_0010, 32'h1234}, "R7 adjust carry");

    // R9 no-op codes
    run_cmd(32'h5);
    exp_time({32'h6, 32'h0000_0010, 32'h1234}, "R9 adjust-at-time");
    run_cmd(32'h7);
    exp_time({32'h6, 32'h0000_0010, 32'h1234}, "R9 reserved code");
    exp_reg(4'd9,  32'hC,          "R9 snap kept");
    exp_reg(4'd11, 32'h8000_0000,  "R9 inc kept");

    // R5 load wins over running increment
    wr(4'd5, 32'h7);
    wr(4'd4, 32'h9);
    wr(4'd3, 32'h0);
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h1);
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h0);
    idle(1);
    exp_time({32'h7, 32'h9, 32'h0}, "R5 load while running");
    exp_reg(4'd0, 32'h0, "R10 enable readback");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule